// File: doc/BRIEF.md
# Two-Operand Addressing Mode Decoder

This block takes a 16-bit two-operand instruction word, works out how its source and destination operands are addressed, and collects the extension words that follow the instruction in program memory. The instruction enters through a valid/ready handshake together with its own address and the current contents of the two registers it names. Extension words arrive on a second valid/ready stream. Once every word the instruction needs has been taken, the block spends one cycle on address arithmetic. It then pulses `done` with the decoded fields, the operand kinds, the effective addresses or operand values, and the instruction length in words.

A few register and mode pairs override the plain register-based modes. With the program counter as base, the source or destination becomes PC-relative, and the source can also take an inline immediate. With the status register as base, the source or destination becomes absolute, and one source mode gives the constant 4 without costing an extension word. When both operands need an extension word, the source word always comes first. An autoincrement source produces a register update request for the execute stage.

Top module: `opdec_top`

## Requirements
- R1: On `done`, `opcode` equals instruction bits [15:12], `src_reg` bits [11:8], `dst_reg` bits [3:0] and `byte_op` bit [6]. The source mode is bits [5:4] and the destination mode bit is bit [7].
- R2: When no special case applies, the source mode picks the kind. Mode 00 gives register (kind 0, `src_ea` = 0). Mode 01 gives indexed (kind 1, `src_ea` = register value + extension word). Mode 10 gives indirect (kind 4, `src_ea` = register value). Mode 11 gives autoincrement (kind 5, `src_ea` = register value).
- R3: Source mode 01 with source register 0 gives symbolic (kind 2). `src_ea` = (address of its extension word + extension word) mod 2^16, where that address is the instruction address + 2.
- R4: Source mode 01 with source register 2 gives absolute (kind 3), with `src_ea` equal to the extension word.
- R5: Source mode 11 with source register 0 gives immediate (kind 6), with `src_ea` equal to the extension word.
- R6: Source mode 10 with source register 2 gives constant (kind 7) with `src_ea` = 4, and it takes no extension word.
- R7: For the destination, mode bit 0 gives register (kind 0, `dst_ea` = 0). Mode bit 1 gives indexed (kind 1, register value + extension word). With register 0 it gives symbolic instead (kind 2, extension word address + extension word, mod 2^16), and with register 2 absolute (kind 3, the extension word itself).
- R8: When both operands take an extension word, the first word belongs to the source and the second to the destination. The destination word's address is then the instruction address + 4.
- R9: `ins_len` equals 1 plus the number of extension words taken, so it is 1, 2 or 3.
- R10: `ins_ready` is high only while idle and `ext_ready` only while an extension word is awaited. `done` is a single-cycle pulse one cycle after the last word (or the instruction itself) is accepted.
- R11: On `done`, `inc_req` is 1 exactly for an autoincrement source. `inc_amt` is then 1 for a byte operation and 2 otherwise, and 0 when there is no request.
- R12: While reset is held and right after it, `ins_ready` is 1 and `ext_ready` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word offered |
| ins_ready | output | 1 | Decoder can take an instruction |
| ins_word | input | 16 | Instruction word |
| ins_pc | input | 16 | Byte address of the instruction word |
| ins_src_val | input | 16 | Contents of the source register |
| ins_dst_val | input | 16 | Contents of the destination register |
| ext_valid | input | 1 | Extension word offered |
| ext_ready | output | 1 | Decoder awaits an extension word |
| ext_word | input | 16 | Extension word |
| done | output | 1 | Decode result valid (one cycle) |
| opcode | output | 4 | Operation field |
| byte_op | output | 1 | Byte operation flag |
| src_reg | output | 4 | Source register number |
| dst_reg | output | 4 | Destination register number |
| src_kind | output | 3 | Source operand kind code |
| dst_kind | output | 2 | Destination operand kind code |
| src_ea | output | 16 | Source address or operand value |
| dst_ea | output | 16 | Destination address |
| ins_len | output | 2 | Instruction length in words |
| inc_req | output | 1 | Source register autoincrement request |
| inc_amt | output | 2 | Autoincrement amount |

## Verification
The bench sweeps every source mode over registers 0, 2 and a plain register, and every destination mode over the same three registers, in both byte and word form. This catches a decoder that lets a plain mode win over a special pair, which would report the wrong kind and take too many or too few extension words. Three-word instructions expose swapped extension words, which would place the immediate at the destination address. They also expose a PC-relative destination computed from the source word's address, which would be off by 2. Random instruction addresses near the top of memory test the wrap of the PC-relative sum. Random stalls on the extension stream would show up as a premature `done` or a wrong instruction length.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  // Instruction field positions (16-bit two-operand format)
  localparam int OPC_LSB = 12;
  localparam int SRC_LSB = 8;
  localparam int AD_BIT  = 7;
  localparam int BW_BIT  = 6;
  localparam int AS_LSB  = 4;
  localparam int DST_LSB = 0;

  // Register numbers with special meaning
  localparam int PC_NUM = 0;
  localparam int SR_NUM = 2;

  typedef enum logic [2:0] {
    SK_REG   = 3'd0,
    SK_IDX   = 3'd1,
    SK_SYM   = 3'd2,
    SK_ABS   = 3'd3,
    SK_IND   = 3'd4,
    SK_AINC  = 3'd5,
    SK_IMM   = 3'd6,
    SK_CONST = 3'd7
  } src_kind_e;

  typedef enum logic [1:0] {
    DK_REG = 2'd0,
    DK_IDX = 2'd1,
    DK_SYM = 2'd2,
    DK_ABS = 2'd3
  } dst_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SRC  = 2'd1,
    ST_DST  = 2'd2,
    ST_EVAL = 2'd3
  } seq_state_e;
endpackage

// File: rtl/opdec_mode_class.sv
module opdec_mode_class
  import opdec_pkg::*;
#(
  parameter int RW     = 4,
  parameter bit IS_DST = 1'b0,
  localparam int KW    = IS_DST ? 2 : 3
) (
  input  logic [1:0]    mode,
  input  logic [RW-1:0] rsel,
  output logic [KW-1:0] kind,
  output logic          need
);
  localparam logic [RW-1:0] PC_SEL = RW'(PC_NUM);
  localparam logic [RW-1:0] SR_SEL = RW'(SR_NUM);

  generate
    if (IS_DST) begin : g_dst
      always_comb begin
        if (mode == 2'b00) begin
          kind = KW'(DK_REG);
          need = 1'b0;
        end else begin
          need = 1'b1;
          if (rsel == PC_SEL)      kind = KW'(DK_SYM);
          else if (rsel == SR_SEL) kind = KW'(DK_ABS);
          else                     kind = KW'(DK_IDX);
        end
      end
    end else begin : g_src
      always_comb begin
        if (rsel == PC_SEL && mode == 2'b01) begin
          kind = KW'(SK_SYM);
          need = 1'b1;
        end else if (rsel == PC_SEL && mode == 2'b11) begin
          kind = KW'(SK_IMM);
          need = 1'b1;
        end else if (rsel == SR_SEL && mode == 2'b01) begin
          kind = KW'(SK_ABS);
          need = 1'b1;
        end else if (rsel == SR_SEL && mode == 2'b10) begin
          kind = KW'(SK_CONST);
          need = 1'b0;
        end else begin
          unique case (mode)
            2'b00:   begin kind = KW'(SK_REG);  need = 1'b0; end
            2'b01:   begin kind = KW'(SK_IDX);  need = 1'b1; end
            2'b10:   begin kind = KW'(SK_IND);  need = 1'b0; end
            default: begin kind = KW'(SK_AINC); need = 1'b0; end
          endcase
        end
      end
    end
  endgenerate
endmodule

// File: rtl/opdec_ea_calc.sv
module opdec_ea_calc
  import opdec_pkg::*;
#(
  parameter int DW     = 16,
  parameter int CG_VAL = 4
) (
  input  logic [2:0]    code,
  input  logic [DW-1:0] rval,
  input  logic [DW-1:0] xword,
  input  logic [DW-1:0] xpc,
  output logic [DW-1:0] ea
);
  localparam logic [DW-1:0] CONST_V = DW'(CG_VAL);

  always_comb begin
    unique case (src_kind_e'(code))
      SK_REG:   ea = '0;
      SK_IDX:   ea = rval + xword;
      SK_SYM:   ea = xpc + xword;
      SK_ABS:   ea = xword;
      SK_IND:   ea = rval;
      SK_AINC:  ea = rval;
      SK_IMM:   ea = xword;
      default:  ea = CONST_V;
    endcase
  end
endmodule

// File: rtl/opdec_seq.sv
module opdec_seq
  import opdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ins_valid,
  input  logic       need_s,
  input  logic       need_d,
  input  logic       ext_valid,
  output logic       ins_ready,
  output logic       ext_ready,
  output logic       accept,
  output logic       fire_src,
  output logic       fire_dst,
  output logic       eval
);
  seq_state_e state_q;
  logic       need_d_q;

  assign ins_ready = (state_q == ST_IDLE);
  assign ext_ready = (state_q == ST_SRC) || (state_q == ST_DST);
  assign accept    = ins_valid && ins_ready;
  assign fire_src  = (state_q == ST_SRC) && ext_valid;
  assign fire_dst  = (state_q == ST_DST) && ext_valid;
  assign eval      = (state_q == ST_EVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      need_d_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          need_d_q <= need_d;
          if (need_s)      state_q <= ST_SRC;
          else if (need_d) state_q <= ST_DST;
          else             state_q <= ST_EVAL;
        end
        ST_SRC: if (ext_valid) state_q <= need_d_q ? ST_DST : ST_EVAL;
        ST_DST: if (ext_valid) state_q <= ST_EVAL;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R10: evaluation lasts exactly one cycle before returning to idle
  assert_eval_once_R10: assert property (@(posedge clk) disable iff (rst)
    eval |=> ins_ready);

  // R8: after a source word, the next awaited word belongs to the destination
  assert_dst_after_src_R8: assert property (@(posedge clk) disable iff (rst)
    (fire_src && need_d_q) |=> (state_q == ST_DST));
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
#(
  parameter int DW     = 16,
  parameter int RW     = 4,
  parameter int STEP   = 2,
  parameter int CG_VAL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [15:0]   ins_word,
  input  logic [DW-1:0] ins_pc,
  input  logic [DW-1:0] ins_src_val,
  input  logic [DW-1:0] ins_dst_val,
  input  logic          ext_valid,
  output logic          ext_ready,
  input  logic [DW-1:0] ext_word,
  output logic          done,
  output logic [3:0]    opcode,
  output logic          byte_op,
  output logic [RW-1:0] src_reg,
  output logic [RW-1:0] dst_reg,
  output logic [2:0]    src_kind,
  output logic [1:0]    dst_kind,
  output logic [DW-1:0] src_ea,
  output logic [DW-1:0] dst_ea,
  output logic [1:0]    ins_len,
  output logic          inc_req,
  output logic [1:0]    inc_amt
);
  localparam logic [DW-1:0] STEP1 = DW'(STEP);
  localparam logic [DW-1:0] STEP2 = DW'(2 * STEP);

  logic       accept, fire_src, fire_dst, eval;
  logic       need_s_in, need_d_in;
  logic [2:0] sk_in;
  logic [1:0] dk_in;

  // Classification of the incoming word, latched on acceptance
  opdec_mode_class #(.RW(RW), .IS_DST(1'b0)) u_src_cls (
    .mode (ins_word[AS_LSB +: 2]),
    .rsel (ins_word[SRC_LSB +: RW]),
    .kind (sk_in),
    .need (need_s_in)
  );

  opdec_mode_class #(.RW(RW), .IS_DST(1'b1)) u_dst_cls (
    .mode ({1'b0, ins_word[AD_BIT]}),
    .rsel (ins_word[DST_LSB +: RW]),
    .kind (dk_in),
    .need (need_d_in)
  );

  opdec_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .ins_valid (ins_valid),
    .need_s    (need_s_in),
    .need_d    (need_d_in),
    .ext_valid (ext_valid),
    .ins_ready (ins_ready),
    .ext_ready (ext_ready),
    .accept    (accept),
    .fire_src  (fire_src),
    .fire_dst  (fire_dst),
    .eval      (eval)
  );

  // Captured instruction context
  logic [3:0]    opc_q;
  logic          bw_q;
  logic [RW-1:0] rs_q, rd_q;
  logic [DW-1:0] pc_q, sv_q, dv_q, xs_q, xd_q;
  logic [2:0]    sk_q;
  logic [1:0]    dk_q;
  logic          ns_q, nd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q <= '0; bw_q <= 1'b0; rs_q <= '0; rd_q <= '0;
      pc_q  <= '0; sv_q <= '0;   dv_q <= '0;
      sk_q  <= '0; dk_q <= '0;   ns_q <= 1'b0; nd_q <= 1'b0;
      xs_q  <= '0; xd_q <= '0;
    end else begin
      if (accept) begin
        opc_q <= ins_word[OPC_LSB +: 4];
        bw_q  <= ins_word[BW_BIT];
        rs_q  <= ins_word[SRC_LSB +: RW];
        rd_q  <= ins_word[DST_LSB +: RW];
        pc_q  <= ins_pc;
        sv_q  <= ins_src_val;
        dv_q  <= ins_dst_val;
        sk_q  <= sk_in;
        dk_q  <= dk_in;
        ns_q  <= need_s_in;
        nd_q  <= need_d_in;
        xs_q  <= '0;
        xd_q  <= '0;
      end
      if (fire_src) xs_q <= ext_word;
      if (fire_dst) xd_q <= ext_word;
    end
  end

  // Address arithmetic, one instance per operand
  logic [DW-1:0] src_xpc, dst_xpc, src_ea_c, dst_ea_c;
  assign src_xpc = pc_q + STEP1;
  assign dst_xpc = pc_q + (ns_q ? STEP2 : STEP1);

  opdec_ea_calc #(.DW(DW), .CG_VAL(CG_VAL)) u_src_ea (
    .code  (sk_q),
    .rval  (sv_q),
    .xword (xs_q),
    .xpc   (src_xpc),
    .ea    (src_ea_c)
  );

  opdec_ea_calc #(.DW(DW), .CG_VAL(CG_VAL)) u_dst_ea (
    .code  ({1'b0, dk_q}),
    .rval  (dv_q),
    .xword (xd_q),
    .xpc   (dst_xpc),
    .ea    (dst_ea_c)
  );

  // Registered result
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0; opcode <= '0; byte_op <= 1'b0; src_reg <= '0; dst_reg <= '0;
      src_kind <= '0; dst_kind <= '0; src_ea <= '0; dst_ea <= '0;
      ins_len <= '0; inc_req <= 1'b0; inc_amt <= '0;
    end else begin
      done <= eval;
      if (eval) begin
        opcode   <= opc_q;
        byte_op  <= bw_q;
        src_reg  <= rs_q;
        dst_reg  <= rd_q;
        src_kind <= sk_q;
        dst_kind <= dk_q;
        src_ea   <= src_ea_c;
        dst_ea   <= dst_ea_c;
        ins_len  <= 2'd1 + {1'b0, ns_q} + {1'b0, nd_q};
        inc_req  <= (sk_q == SK_AINC);
        inc_amt  <= (sk_q == SK_AINC) ? (bw_q ? 2'd1 : 2'd2) : 2'd0;
      end
    end
  end

  // R10: the two ready outputs are never high together
  assert_ready_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(ins_ready && ext_ready));

  // R10: done is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: a stalled extension stream keeps the decoder waiting
  assert_ext_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (ext_ready && !ext_valid) |=> ext_ready);

  // R6: constant source with register destination is a one-word instruction
  assert_const_noext_R6: assert property (@(posedge clk) disable iff (rst)
    (done && src_kind == SK_CONST && dst_kind == DK_REG) |-> (ins_len == 2'd1));

  // R5: an immediate source always costs an extension word
  assert_imm_len_R5: assert property (@(posedge clk) disable iff (rst)
    (done && src_kind == SK_IMM) |-> (ins_len >= 2'd2));

  // R9: a reported length is never zero
  assert_len_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (ins_len != 2'd0));

  // R11: increment requests only come with autoincrement sources
  assert_inc_kind_R11: assert property (@(posedge clk) disable iff (rst)
    (done && inc_req) |-> (src_kind == SK_AINC && inc_amt != 2'd0));
endmodule

// File: tb/sim_opdec_top.sv
module sim_opdec_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [15:0] ins_word = '0, ins_pc = '0, ins_src_val = '0, ins_dst_val = '0;
  logic        ext_valid = 1'b0;
  logic [15:0] ext_word = '0;
  logic        ins_ready, ext_ready, done, byte_op, inc_req;
  logic [3:0]  opcode, src_reg, dst_reg;
  logic [2:0]  src_kind;
  logic [1:0]  dst_kind, ins_len, inc_amt;
  logic [15:0] src_ea, dst_ea;

  always #(CLK_PERIOD/2) clk = ~clk;

  opdec_top u0 (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .ins_pc(ins_pc), .ins_src_val(ins_src_val),
    .ins_dst_val(ins_dst_val), .ext_valid(ext_valid), .ext_ready(ext_ready),
    .ext_word(ext_word), .done(done), .opcode(opcode), .byte_op(byte_op),
    .src_reg(src_reg), .dst_reg(dst_reg), .src_kind(src_kind), .dst_kind(dst_kind),
    .src_ea(src_ea), .dst_ea(dst_ea), .ins_len(ins_len), .inc_req(inc_req),
    .inc_amt(inc_amt)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [15:0] xq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lcg(input logic [31:0] s);
    return s * 32'd1664525 + 32'd1013904223;
  endfunction

  // Classification from the requirements (R2..R7)
  task automatic classify(input logic [15:0] w, output int sk, output int dk,
                          output int ns, output int nd);
    int as_m, rs, rd, ad;
    as_m = int'(w[5:4]); rs = int'(w[11:8]); rd = int'(w[3:0]); ad = int'(w[7]);
    if (rs == 0 && as_m == 1)      begin sk = 2; ns = 1; end
    else if (rs == 0 && as_m == 3) begin sk = 6; ns = 1; end
    else if (rs == 2 && as_m == 1) begin sk = 3; ns = 1; end
    else if (rs == 2 && as_m == 2) begin sk = 7; ns = 0; end
    else begin
      case (as_m)
        0: begin sk = 0; ns = 0; end
        1: begin sk = 1; ns = 1; end
        2: begin sk = 4; ns = 0; end
        default: begin sk = 5; ns = 0; end
      endcase
    end
    if (ad == 0) begin dk = 0; nd = 0; end
    else begin
      nd = 1;
      dk = (rd == 0) ? 2 : (rd == 2) ? 3 : 1;
    end
  endtask

  // Behavioural reference state
  int m_st = 0;
  bit m_done = 0;
  int e_sk, e_dk, e_ns, e_nd;
  logic [15:0] e_w, e_pc, e_sv, e_dv, e_xs, e_xd;
  logic [15:0] r_sea, r_dea;

  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      m_done = 0;
      case (m_st)
        0: if (ins_valid) begin
             e_w = ins_word; e_pc = ins_pc; e_sv = ins_src_val; e_dv = ins_dst_val;
             e_xs = 0; e_xd = 0;
             classify(e_w, e_sk, e_dk, e_ns, e_nd);
             m_st = e_ns ? 1 : (e_nd ? 2 : 3);
           end
        1: if (ext_valid) begin e_xs = ext_word; m_st = e_nd ? 2 : 3; end
        2: if (ext_valid) begin e_xd = ext_word; m_st = 3; end
        default: begin m_st = 0; m_done = 1; end
      endcase
      chk("R10 ins_ready", 32'(ins_ready), 32'(m_st == 0));
      chk("R10 ext_ready", 32'(ext_ready), 32'(m_st == 1 || m_st == 2));
      chk("R10 done", 32'(done), 32'(m_done));
      if (m_done) begin
        case (e_sk)
          1: r_sea = e_sv + e_xs;
          2: r_sea = e_pc + 16'd2 + e_xs;
          3, 6: r_sea = e_xs;
          4, 5: r_sea = e_sv;
          7: r_sea = 16'd4;
          default: r_sea = 16'd0;
        endcase
        case (e_dk)
          1: r_dea = e_dv + e_xd;
          2: r_dea = e_pc + (e_ns ? 16'd4 : 16'd2) + e_xd;
          3: r_dea = e_xd;
          default: r_dea = 16'd0;
        endcase
        chk("R1 opcode", 32'(opcode), 32'(e_w[15:12]));
        chk("R1 byte_op", 32'(byte_op), 32'(e_w[6]));
        chk("R1 src_reg", 32'(src_reg), 32'(e_w[11:8]));
        chk("R1 dst_reg", 32'(dst_reg), 32'(e_w[3:0]));
        case (e_sk)
          2: chk("R3 symbolic src", {13'd0, src_kind, src_ea}, {13'd0, 3'd2, r_sea});
          3: chk("R4 absolute src", {13'd0, src_kind, src_ea}, {13'd0, 3'd3, r_sea});
          6: chk("R5 immediate src", {13'd0, src_kind, src_ea}, {13'd0, 3'd6, r_sea});
          7: chk("R6 constant src", {13'd0, src_kind, src_ea}, {13'd0, 3'd7, r_sea});
          default: chk("R2 normal src", {13'd0, src_kind, src_ea}, {13'(0), 3'(e_sk), r_sea});
        endcase
        if (e_ns && e_nd)
          chk("R8 dst after src word", {14'd0, dst_kind, dst_ea}, {14'd0, 2'(e_dk), r_dea});
        else
          chk("R7 dst", {14'd0, dst_kind, dst_ea}, {14'd0, 2'(e_dk), r_dea});
        chk("R9 ins_len", 32'(ins_len), 32'(1 + e_ns + e_nd));
        chk("R11 inc", {inc_req, inc_amt},
            (e_sk == 5) ? {1'b1, (e_w[6] ? 2'd1 : 2'd2)} : 3'b000);
      end
    end
  end

  // Extension word stream with pseudo-random stalls
  bit rdy_seen = 0;
  initial begin
    forever begin
      @(negedge clk); #1;
      if (ext_valid && rdy_seen) void'(xq.pop_front());
      seed = lcg(seed);
      if (xq.size() > 0 && seed[20:19] != 2'b00) begin
        ext_valid = 1'b1; ext_word = xq[0];
      end else begin
        ext_valid = 1'b0; ext_word = 16'h0;
      end
      rdy_seen = ext_ready;
    end
  end

  task automatic send(input logic [15:0] w, input logic [15:0] pc,
                      input logic [15:0] sv, input logic [15:0] dv,
                      input logic [15:0] x0, input logic [15:0] x1);
    int sk, dk, ns, nd;
    bit acc;
    classify(w, sk, dk, ns, nd);
    if (ns + nd >= 1) xq.push_back(x0);
    if (ns + nd == 2) xq.push_back(x1);
    @(negedge clk); #1;
    ins_word = w; ins_pc = pc; ins_src_val = sv; ins_dst_val = dv; ins_valid = 1'b1;
    do begin
      acc = ins_ready;
      @(negedge clk); #1;
    end while (!acc);
    ins_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset ins_ready", 32'(ins_ready), 32'd1);
    chk("R12 reset ext_ready", 32'(ext_ready), 32'd0);
    chk("R12 reset done", 32'(done), 32'd0);
    #1 rst = 1'b0;
    // R5/R4/R8: immediate to absolute, three words, source word first
    send(16'h40B2, 16'hC000, 16'h1111, 16'h2222, 16'h5A80, 16'h0120);
    // R5/R7: immediate to register, two words
    send(16'h4031, 16'hC006, 16'h0, 16'h0, 16'h03FF, 16'h0);
    // R3/R7: PC-relative sums wrapping past the top of memory
    send(16'h4090, 16'hFFFA, 16'h0, 16'h0, 16'h0010, 16'h0020);
    // R6: constant 4, no extension word, back to back
    send(16'h5223, 16'h1000, 16'h0, 16'h0, 16'h0, 16'h0);
    send(16'h5263, 16'h1002, 16'h0, 16'h0, 16'h0, 16'h0);
    // Sweep: all source modes x registers 0, 2, 5; destination modes x 0, 2, 7; byte/word
    for (int a = 0; a < 4; a++)
      for (int s = 0; s < 3; s++)
        for (int d = 0; d < 2; d++)
          for (int r = 0; r < 3; r++)
            for (int b = 0; b < 2; b++) begin
              logic [15:0] w;
              seed = lcg(seed);
              w = {seed[27:24], (s == 0) ? 4'd0 : (s == 1) ? 4'd2 : 4'd5, 1'(d), 1'(b),
                   2'(a), (r == 0) ? 4'd0 : (r == 1) ? 4'd2 : 4'd7};
              send(w, {seed[15:1], 1'b0}, seed[31:16], seed[23:8],
                   seed[19:4] ^ 16'hA5A5, seed[29:14]);
            end
    // Random instructions
    for (int i = 0; i < 300; i++) begin
      logic [31:0] s1, s2;
      seed = lcg(seed); s1 = seed;
      seed = lcg(seed); s2 = seed;
      send(s1[15:0], {s1[31:17], 1'b0}, s2[15:0], s2[31:16], s2[23:8], s1[27:12]);
    end
    repeat (20) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R10 actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule